// File: doc/BRIEF.md
# Sector-Partitioned Replacement Victim Selector

This block chooses which way of one cache set is refilled after a miss, in a set-associative cache where every line carries a two-bit sector label. Software gives each of the four sectors its own ceiling on the number of ways it may hold. On a miss, the block looks at the set's valid bits, the sector label of each way, the age of each way and the requester's sector. It then picks a victim so that the sector occupancy drifts toward the programmed ceilings. This is not plain least-recently-used replacement over the whole set.

Sector membership is only a label on each line. It needs no address window, and it is not saved or restored on a context switch. Sector 0 is meant for instruction fetch, ordinary data and streaming data. Sectors 1 to 3 are meant for reusable data that software classes separately. One of them can be reserved for a helper processor so that its traffic does not evict compute data.

The block answers each miss one cycle later. It returns the victim way, a code giving the reason for the choice, and the rewritten sector labels and ages for the whole set. The caller writes these back together with the refill. A ceiling that is at least the way count means the sector is unrestricted.

Top module: `sps_victim_sel`

## Requirements
- R1: After reset, `vic_valid` is 0 and every sector ceiling equals NUM_WAYS.
- R2: `vic_valid` is 1 in exactly the cycle after a cycle with `miss_req` high, and 0 after a cycle with `miss_req` low.
- R3: If the requester's sector holds at least one valid way and holds at least as many valid ways as its ceiling, the victim is the oldest valid way of that sector, with cause 0.
- R4: Otherwise, if any way is invalid, the victim is the lowest-numbered invalid way, with cause 1. A ceiling of 0 on a sector that holds no ways also leads to this rule.
- R5: Otherwise, if any sector holds more valid ways than its ceiling, the victim is the oldest valid way among the lines of all such sectors, with cause 2.
- R6: Otherwise the victim is the oldest way of the whole set, with cause 3.
- R7: Age 0 means most recently used, and a larger value means older. When several candidates share the oldest age, the lowest-numbered way wins.
- R8: `new_sector` equals `way_sector`, except that the victim's two-bit field (bits 2*w+1:2*w for way w) holds the requester's sector.
- R9: In `new_age` (bits AGE_W*w +: AGE_W for way w), the victim gets age 0. Every other way younger than the victim's old age ages by one. All other ways keep their age.
- R10: A write on the configuration port changes only the ceiling of the addressed sector, and it applies to misses from the next cycle on. Ceilings whose sum exceeds NUM_WAYS are legal, and each sector is still judged against its own ceiling only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Ceiling write strobe |
| cfg_sector | input | 2 | Sector whose ceiling is written |
| cfg_limit | input | CNT_W | New ceiling value |
| miss_req | input | 1 | Miss needing a victim this cycle |
| miss_sector | input | 2 | Sector of the missing access |
| way_valid | input | NUM_WAYS | Valid bit of each way |
| way_sector | input | 2*NUM_WAYS | Sector label of each way |
| way_age | input | AGE_W*NUM_WAYS | Age of each way |
| vic_valid | output | 1 | Victim result present |
| vic_way | output | IDX_W | Chosen way |
| vic_cause | output | 2 | Rule that chose it (0 own, 1 free, 2 over ceiling, 3 global) |
| new_sector | output | 2*NUM_WAYS | Sector labels after refill |
| new_age | output | AGE_W*NUM_WAYS | Ages after refill |

## Verification
The bench builds the block with NUM_WAYS=4 and AGE_W=2, so a set's valid bits and sector labels take only 4,096 combinations. It sweeps all of them for every requester sector. It does this under four ceiling sets: unrestricted, tight, mixed including a zero ceiling, and over-subscribed. Age patterns rotate between distinct and tied values. This small size brings every selection rule, every tie and the zero-ceiling fall-through within exhaustive reach.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int SECTORS = 4;
  localparam int SEC_W   = 2;

  typedef enum logic [1:0] {
    CAUSE_OWN    = 2'd0,
    CAUSE_FREE   = 2'd1,
    CAUSE_OVER   = 2'd2,
    CAUSE_GLOBAL = 2'd3
  } vic_cause_e;
endpackage

// File: rtl/sps_limit_regs.sv
module sps_limit_regs
  import sps_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SEC_W-1:0]           cfg_sector,
  input  logic [CNT_W-1:0]           cfg_limit,
  output logic [SECTORS*CNT_W-1:0]   limits
);
  for (genvar s = 0; s < SECTORS; s++) begin : g_lim
    logic [CNT_W-1:0] lim_q;
    logic             hit_w;
    assign hit_w = cfg_we && (cfg_sector == SEC_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)     lim_q <= CNT_W'(NUM_WAYS);
      else if (hit_w) lim_q <= cfg_limit;
    end
    assign limits[s*CNT_W +: CNT_W] = lim_q;
  end
endmodule

// File: rtl/sps_occupancy.sv
module sps_occupancy
  import sps_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic [NUM_WAYS-1:0]        way_valid,
  input  logic [NUM_WAYS*SEC_W-1:0]  way_sector,
  input  logic [SECTORS*CNT_W-1:0]   limits,
  output logic [SECTORS*CNT_W-1:0]   occ,
  output logic [SECTORS-1:0]         over_sec
);
  function automatic logic [CNT_W-1:0] tally(
    input logic [NUM_WAYS-1:0]       v,
    input logic [NUM_WAYS*SEC_W-1:0] tags,
    input logic [SEC_W-1:0]          sec
  );
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (v[i] && (tags[i*SEC_W +: SEC_W] == sec)) n = n + CNT_W'(1);
    return n;
  endfunction

  for (genvar s = 0; s < SECTORS; s++) begin : g_occ
    logic [CNT_W-1:0] cnt;
    assign cnt = tally(way_valid, way_sector, SEC_W'(s));
    assign occ[s*CNT_W +: CNT_W] = cnt;
    assign over_sec[s] = cnt > limits[s*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/sps_oldest_pick.sv
module sps_oldest_pick #(
  parameter int NUM_WAYS = 24,
  parameter int AGE_W    = 5,
  localparam int IDX_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]        cand,
  input  logic [NUM_WAYS*AGE_W-1:0]  ages,
  output logic                       found,
  output logic [IDX_W-1:0]           idx
);
  logic [AGE_W-1:0] best;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (cand[i] && (!found || (ages[i*AGE_W +: AGE_W] > best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = ages[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/sps_victim_sel.sv
module sps_victim_sel
  import sps_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  parameter int AGE_W    = 5,
  localparam int CNT_W = $clog2(NUM_WAYS + 1),
  localparam int IDX_W = $clog2(NUM_WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sector,
  input  logic [CNT_W-1:0]           cfg_limit,
  input  logic                       miss_req,
  input  logic [1:0]                 miss_sector,
  input  logic [NUM_WAYS-1:0]        way_valid,
  input  logic [NUM_WAYS*2-1:0]      way_sector,
  input  logic [NUM_WAYS*AGE_W-1:0]  way_age,
  output logic                       vic_valid,
  output logic [IDX_W-1:0]           vic_way,
  output logic [1:0]                 vic_cause,
  output logic [NUM_WAYS*2-1:0]      new_sector,
  output logic [NUM_WAYS*AGE_W-1:0]  new_age
);
  logic [SECTORS*CNT_W-1:0] limits;
  logic [SECTORS*CNT_W-1:0] occ;
  logic [SECTORS-1:0]       over_sec;

  sps_limit_regs #(.NUM_WAYS(NUM_WAYS)) u_limits (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sector(cfg_sector),
    .cfg_limit(cfg_limit), .limits(limits)
  );

  sps_occupancy #(.NUM_WAYS(NUM_WAYS)) u_occ (
    .way_valid(way_valid), .way_sector(way_sector), .limits(limits),
    .occ(occ), .over_sec(over_sec)
  );

  // Requester's own occupancy and ceiling
  logic [CNT_W-1:0] req_occ, req_lim;
  assign req_occ = occ[int'(miss_sector)*CNT_W +: CNT_W];
  assign req_lim = limits[int'(miss_sector)*CNT_W +: CNT_W];

  // Candidate masks, one per selection rule (index = cause code)
  logic [SECTORS-1:0][NUM_WAYS-1:0]       cand;
  logic [SECTORS-1:0][NUM_WAYS*AGE_W-1:0] cand_age;
  logic [SECTORS-1:0]                     pick_found;
  logic [SECTORS-1:0][IDX_W-1:0]          pick_idx;

  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      cand[0][i] = way_valid[i] && (way_sector[i*2 +: 2] == miss_sector);
      cand[1][i] = !way_valid[i];
      cand[2][i] = way_valid[i] && over_sec[way_sector[i*2 +: 2]];
      cand[3][i] = 1'b1;
    end
  end

  for (genvar k = 0; k < SECTORS; k++) begin : g_pick
    if (k == 1) begin : g_first
      // Equal ages reduce the oldest-pick to a lowest-index pick
      assign cand_age[k] = '0;
    end else begin : g_lru
      assign cand_age[k] = way_age;
    end
    sps_oldest_pick #(.NUM_WAYS(NUM_WAYS), .AGE_W(AGE_W)) u_pick (
      .cand(cand[k]), .ages(cand_age[k]),
      .found(pick_found[k]), .idx(pick_idx[k])
    );
  end

  // Named decision events
  logic       req_at_cap;
  logic       free_avail;
  logic       over_avail;
  vic_cause_e sel_cause;
  logic [IDX_W-1:0] sel_way;

  assign req_at_cap = pick_found[0] && (req_occ >= req_lim);
  assign free_avail = pick_found[1];
  assign over_avail = pick_found[2];

  always_comb begin
    if (req_at_cap)         sel_cause = CAUSE_OWN;
    else if (free_avail)    sel_cause = CAUSE_FREE;
    else if (over_avail)    sel_cause = CAUSE_OVER;
    else if (pick_found[3]) sel_cause = CAUSE_GLOBAL;
    else                    sel_cause = CAUSE_OWN;
  end

  assign sel_way = pick_idx[sel_cause];

  function automatic logic [NUM_WAYS*2-1:0] retag(
    input logic [NUM_WAYS*2-1:0] tags,
    input logic [IDX_W-1:0]      w,
    input logic [1:0]            sec
  );
    logic [NUM_WAYS*2-1:0] r;
    r = tags;
    for (int i = 0; i < NUM_WAYS; i++)
      if (IDX_W'(i) == w) r[i*2 +: 2] = sec;
    return r;
  endfunction

  function automatic logic [NUM_WAYS*AGE_W-1:0] reage(
    input logic [NUM_WAYS*AGE_W-1:0] ages,
    input logic [IDX_W-1:0]          w
  );
    logic [NUM_WAYS*AGE_W-1:0] r;
    logic [AGE_W-1:0]          pivot;
    pivot = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (IDX_W'(i) == w) pivot = ages[i*AGE_W +: AGE_W];
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (IDX_W'(i) == w)
        r[i*AGE_W +: AGE_W] = '0;
      else if (ages[i*AGE_W +: AGE_W] < pivot)
        r[i*AGE_W +: AGE_W] = ages[i*AGE_W +: AGE_W] + AGE_W'(1);
      else
        r[i*AGE_W +: AGE_W] = ages[i*AGE_W +: AGE_W];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid  <= 1'b0;
      vic_way    <= '0;
      vic_cause  <= '0;
      new_sector <= '0;
      new_age    <= '0;
    end else begin
      vic_valid <= miss_req;
      if (miss_req) begin
        vic_way    <= sel_way;
        vic_cause  <= sel_cause;
        new_sector <= retag(way_sector, sel_way, miss_sector);
        new_age    <= reage(way_age, sel_way);
      end
    end
  end
endmodule

// File: rtl/sps_victim_sel_chk.sv
module sps_victim_sel_chk
  import sps_pkg::*;
#(
  parameter int NUM_WAYS = 24,
  parameter int AGE_W    = 5,
  localparam int IDX_W = $clog2(NUM_WAYS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       miss_req,
  input logic [1:0]                 miss_sector,
  input logic [NUM_WAYS-1:0]        way_valid,
  input logic [NUM_WAYS*2-1:0]      way_sector,
  input logic                       vic_valid,
  input logic [IDX_W-1:0]           vic_way,
  input logic [1:0]                 vic_cause,
  input logic [NUM_WAYS*2-1:0]      new_sector,
  input logic [NUM_WAYS*AGE_W-1:0]  new_age
);
  logic [NUM_WAYS-1:0]   p_valid;
  logic [NUM_WAYS*2-1:0] p_sector;
  logic [1:0]            p_req;
  always_ff @(posedge clk) begin
    p_valid  <= way_valid;
    p_sector <= way_sector;
    p_req    <= miss_sector;
  end

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |=> vic_valid); // R2
  AST_NO_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req |=> !vic_valid); // R2
  AST_OWN_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_cause == CAUSE_OWN) |-> (p_valid[vic_way] && p_sector[vic_way*2 +: 2] == p_req)); // R3
  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_cause == CAUSE_FREE) |-> !p_valid[vic_way]); // R4
  AST_OVER_IS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_cause == CAUSE_OVER) |-> p_valid[vic_way]); // R5
  AST_VICTIM_RETAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (new_sector[vic_way*2 +: 2] == p_req)); // R8
  AST_VICTIM_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (new_age[vic_way*AGE_W +: AGE_W] == '0)); // R9
endmodule

bind sps_victim_sel sps_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .AGE_W(AGE_W)) u_chk (.*);

// File: tb/sps_victim_sel_tb.sv
module sps_victim_sel_tb;
  localparam int W  = 4;
  localparam int AW = 2;
  localparam int CW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sector;
  logic [CW-1:0] cfg_limit;
  logic          miss_req;
  logic [1:0]    miss_sector;
  logic [W-1:0]  way_valid;
  logic [2*W-1:0]  way_sector;
  logic [AW*W-1:0] way_age;
  logic          vic_valid;
  logic [IW-1:0] vic_way;
  logic [1:0]    vic_cause;
  logic [2*W-1:0]  new_sector;
  logic [AW*W-1:0] new_age;

  sps_victim_sel #(.NUM_WAYS(W), .AGE_W(AW)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int lim[4];
  int cyc = 0;
  bit done = 0;

  task automatic check(input string rq, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int age_of(input int a, input int i);
    return (a >> (AW * i)) & 3;
  endfunction

  // Scans high to low with >=, so equal ages settle on the lowest way
  function automatic int oldest(input int mask, input int a);
    int best = -1;
    for (int i = W - 1; i >= 0; i--)
      if (((mask >> i) & 1) != 0)
        if (best < 0 || age_of(a, i) >= age_of(a, best)) best = i;
    return best;
  endfunction

  task automatic run_req(input int v, input int t, input int a, input int r);
    int cnt[4];
    int own_m, over_m, ev, ec, es, ea, first_free, av;
    string tag;
    for (int s = 0; s < 4; s++) cnt[s] = 0;
    own_m = 0; over_m = 0; first_free = -1;
    for (int i = 0; i < W; i++)
      if (((v >> i) & 1) != 0) cnt[(t >> (2*i)) & 3]++;
    for (int i = W - 1; i >= 0; i--) begin
      if (((v >> i) & 1) == 0) first_free = i;
      else begin
        if (((t >> (2*i)) & 3) == r) own_m |= (1 << i);
        if (cnt[(t >> (2*i)) & 3] > lim[(t >> (2*i)) & 3]) over_m |= (1 << i);
      end
    end
    if (cnt[r] > 0 && cnt[r] >= lim[r]) begin ec = 0; ev = oldest(own_m, a); tag = "R3"; end
    else if (first_free >= 0)           begin ec = 1; ev = first_free;       tag = "R4"; end
    else if (over_m != 0)               begin ec = 2; ev = oldest(over_m, a); tag = "R5"; end
    else                                begin ec = 3; ev = oldest(15, a);     tag = "R6"; end
    es = (t & ~(3 << (2*ev))) | (r << (2*ev));
    av = age_of(a, ev);
    ea = 0;
    for (int i = 0; i < W; i++) begin
      int x = age_of(a, i);
      if (i != ev) ea |= ((x < av) ? x + 1 : x) << (AW * i);
    end
    way_valid = v[W-1:0]; way_sector = t[2*W-1:0]; way_age = a[AW*W-1:0];
    miss_sector = r[1:0]; miss_req = 1'b1;
    @(negedge clk);
    miss_req = 1'b0;
    check("R2 result present", int'(vic_valid), 1);
    check({tag, " victim way"}, int'(vic_way), ev);
    check({tag, " cause"}, int'(vic_cause), ec);
    check("R8 new sectors", int'(new_sector), es);
    check("R9 new ages", int'(new_age), ea);
  endtask

  task automatic idle();
    miss_req = 1'b0;
    @(negedge clk);
    check("R2 no request", int'(vic_valid), 0);
  endtask

  task automatic set_limit(input int s, input int l);
    cfg_we = 1'b1; cfg_sector = s[1:0]; cfg_limit = l[CW-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    lim[s] = l;
  endtask

  initial begin
    int pats[4];
    int sets[4][4];
    pats[0] = 8'hE4; pats[1] = 8'h1B; pats[2] = 8'h8A; pats[3] = 8'h3D;
    sets[0] = '{4, 4, 4, 4};
    sets[1] = '{1, 1, 1, 1};
    sets[2] = '{0, 2, 1, 3};
    sets[3] = '{3, 3, 3, 3};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sector = '0; cfg_limit = '0;
    miss_req = 1'b0; miss_sector = '0; way_valid = '0; way_sector = '0; way_age = '0;
    for (int s = 0; s < 4; s++) lim[s] = W;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(vic_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(vic_valid), 0);
    // R1: default ceiling = W, so a full sector-0 set is at its cap
    run_req(15, 8'h00, 8'hE4, 0);
    check("R1 default ceiling", int'(vic_cause), 0);
    // R7: all ages tied
    run_req(15, 8'h00, 8'h00, 1);
    check("R7 global tie", int'(vic_way), 0);
    run_req(15, 8'h00, 8'h00, 0);
    check("R7 own tie", int'(vic_way), 0);
    idle();
    // R10: only sector 2 ceiling lowered
    set_limit(2, 1);
    run_req(15, 8'h0A, 8'hE4, 0);
    check("R10 over ceiling way", int'(vic_way), 1);
    check("R10 over ceiling cause", int'(vic_cause), 2);
    run_req(15, 8'h00, 8'hE4, 0);
    check("R10 other sector unchanged", int'(vic_cause), 0);
    // Exhaustive sweep
    for (int ls = 0; ls < 4; ls++) begin
      for (int s = 0; s < 4; s++) set_limit(s, sets[ls][s]);
      for (int v = 0; v < 16; v++) begin
        for (int t = 0; t < 256; t++)
          for (int r = 0; r < 4; r++)
            run_req(v, t, pats[(v + t + r) % 4], r);
        idle();
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule